// File: doc/BRIEF.md
# Fair Round-Robin Bus Arbiter

This block decides which of up to eight agents on a shared parallel bus may start the next transaction. Every agent drives an active-low request line. The arbiter answers each one on an active-low grant line. At most one grant is low at any time. Agent 0 is the local bridge and the other agents are external. All agents share one priority level. A rotating pointer chooses the winner, so an agent that is requesting is always served after the other requesters have had one turn each.

The arbiter also watches the bus frame line, which is active-low, to decide when a grant has done its job. A grant is withdrawn in three cases:

- frame goes from deasserted to asserted, which means the owner has started its transaction;
- the owner has left frame deasserted for a fixed number of cycles after it was granted;
- the owner lets go of its request.

After a grant is withdrawn, there is one cycle with no grant. The next winner is chosen on the edge after that.

Top module: `fair_bus_arbiter`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit of `gnt_n` is high after that edge.
- R2: At most one bit of `gnt_n` is low in any cycle.
- R3: A new winner is the first agent with a low request, searching upward from the index just after the previous winner and wrapping from N-1 to 0. After reset the search begins at index 0.
- R4: If no grant is low and at least one request is low at a rising edge, the winner's grant is low after that edge.
- R5: A held grant is released (all of `gnt_n` high) after an edge at which `frame_n` is low, provided `frame_n` was high at the edge before.
- R6: A held grant is released after the IDLE_LIMIT-th edge (16 by default) at which `frame_n` is high since the grant was issued.
- R7: A held grant is released after an edge at which the owner's `req_n` bit is high.
- R8: When none of the release conditions holds, the grant stays with the same owner.
- R9: After a release, `gnt_n` stays all-high for exactly one cycle if a request is pending. The next grant is then driven on the following edge.
- R10: If every request is high while no grant is held, `gnt_n` stays all-high.
- R11: Edges at which `frame_n` is low do not add to the idle count. The count starts again from zero at every new grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active-high |
| req_n | input | NUM_AGENTS | Request from each agent, active-low; bit 0 is the local bridge |
| frame_n | input | 1 | Bus frame line, active-low |
| gnt_n | output | NUM_AGENTS | Grant to each agent, active-low |

## Verification
The bench targets the three release paths one at a time.

- **Frame start.** A frame that is already low when the grant is issued must not count as a start. A design that only looks at the level of frame would release too early.
- **Idle timeout.** Fifteen frame-high cycles must keep the grant and the sixteenth must drop it. Several cases must be handled:
  - an off-by-one counter would release one edge early or one edge late;
  - a counter that also counts frame-low cycles would release too early;
  - a counter that is not cleared at the next grant would cut that grant short.
- **Request withdrawal.** The owner lets go of its request while other agents are still requesting.

With every request held low, a run of forced releases must visit the agents in strict rotation. A priority encoder with a fixed order would keep returning to the lowest index, and that breaks the sequence.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;

    localparam int MAX_AGENTS = 8;
    localparam int IDX_W      = 3;

    typedef enum logic {
        ARB_FREE = 1'b0,
        ARB_HELD = 1'b1
    } arb_state_e;

    typedef struct packed {
        arb_state_e       state;
        logic [IDX_W-1:0] owner;
        logic [IDX_W-1:0] last;
    } arb_ctx_t;

    function automatic int unsigned wrap_next(input int unsigned base,
                                              input int unsigned step,
                                              input int unsigned n);
        return (base + step) % n;
    endfunction

endpackage

// File: rtl/arb_rr_select.sv
module arb_rr_select
    import pci_arb_pkg::*;
#(
    parameter int NUM_AGENTS = 4
) (
    input  logic [NUM_AGENTS-1:0] req_act,
    input  logic [IDX_W-1:0]      last_idx,
    output logic                  found,
    output logic [IDX_W-1:0]      win
);

    int unsigned cand;

    always_comb begin
        found = 1'b0;
        win   = '0;
        cand  = 0;
        for (int k = 1; k <= NUM_AGENTS; k++) begin
            cand = wrap_next(32'(last_idx), 32'(k), 32'(NUM_AGENTS));
            if (!found && req_act[cand[IDX_W-1:0]]) begin
                found = 1'b1;
                win   = cand[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/arb_idle_timer.sv
module arb_idle_timer #(
    parameter int IDLE_LIMIT = 16,
    localparam int CNT_W     = $clog2(IDLE_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic idle_tick,
    output logic expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (idle_tick && cnt_q != CNT_W'(IDLE_LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = idle_tick && (cnt_q == CNT_W'(IDLE_LIMIT - 1));

endmodule

// File: rtl/arb_frame_edge.sv
module arb_frame_edge (
    input  logic clk,
    input  logic rst,
    input  logic frame_n,
    output logic start
);

    logic frame_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_prev_q <= 1'b1;
        end else begin
            frame_prev_q <= frame_n;
        end
    end

    assign start = frame_prev_q && !frame_n;

endmodule

// File: rtl/fair_bus_arbiter.sv
module fair_bus_arbiter
    import pci_arb_pkg::*;
#(
    parameter int NUM_AGENTS = 4,
    parameter int IDLE_LIMIT = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_AGENTS-1:0] req_n,
    input  logic                  frame_n,
    output logic [NUM_AGENTS-1:0] gnt_n
);

    localparam logic [IDX_W-1:0] LAST_INIT = IDX_W'(NUM_AGENTS - 1);

    arb_ctx_t               ctx_q;
    logic [NUM_AGENTS-1:0]  req_act;
    logic                   pick_found;
    logic [IDX_W-1:0]       pick_idx;
    logic                   frame_start;
    logic                   idle_expire;
    logic                   owner_drop;
    logic                   release_now;
    logic                   held;

    assign req_act = ~req_n;
    assign held    = (ctx_q.state == ARB_HELD);

    arb_rr_select #(.NUM_AGENTS(NUM_AGENTS)) u_sel (
        .req_act  (req_act),
        .last_idx (ctx_q.last),
        .found    (pick_found),
        .win      (pick_idx)
    );

    arb_frame_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .start   (frame_start)
    );

    arb_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .clear     (!held),
        .idle_tick (held && frame_n),
        .expire    (idle_expire)
    );

    assign owner_drop  = !req_act[ctx_q.owner];
    assign release_now = frame_start || idle_expire || owner_drop;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q.state <= ARB_FREE;
            ctx_q.owner <= '0;
            ctx_q.last  <= LAST_INIT;
        end else begin
            case (ctx_q.state)
                ARB_FREE: begin
                    if (pick_found) begin
                        ctx_q.state <= ARB_HELD;
                        ctx_q.owner <= pick_idx;
                        ctx_q.last  <= pick_idx;
                    end
                end
                ARB_HELD: begin
                    if (release_now) begin
                        ctx_q.state <= ARB_FREE;
                    end
                end
                default: ctx_q.state <= ARB_FREE;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_gnt
        assign gnt_n[i] = !(held && (ctx_q.owner == IDX_W'(i)));
    end

endmodule

// File: rtl/fair_bus_arbiter_chk.sv
module fair_bus_arbiter_chk #(
    parameter int NUM_AGENTS = 4,
    parameter int IDLE_LIMIT = 16,
    localparam int CW        = $clog2(IDLE_LIMIT + 1)
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_AGENTS-1:0] req_n,
    input logic                  frame_n,
    input logic [NUM_AGENTS-1:0] gnt_n
);

    logic          frame_q;
    logic [CW-1:0] idle_q;
    logic          granted;

    assign granted = !(&gnt_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= 1'b1;
            idle_q  <= '0;
        end else begin
            frame_q <= frame_n;
            if (!granted) begin
                idle_q <= '0;
            end else if (frame_n && idle_q != CW'(IDLE_LIMIT)) begin
                idle_q <= idle_q + 1'b1;
            end
        end
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> &gnt_n);

    // R2
    a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
        $countones(~gnt_n) <= 1);

    // R4
    a_r4_grant_latency: assert property (@(posedge clk) disable iff (rst)
        (&gnt_n && !(&req_n)) |=> granted);

    // R5
    a_r5_frame_start: assert property (@(posedge clk) disable iff (rst)
        (granted && frame_q && !frame_n) |=> &gnt_n);

    // R6
    a_r6_idle_timeout: assert property (@(posedge clk) disable iff (rst)
        (granted && frame_n && idle_q == CW'(IDLE_LIMIT - 1)) |=> &gnt_n);

    // R7
    a_r7_owner_drop: assert property (@(posedge clk) disable iff (rst)
        (|(~gnt_n & req_n)) |=> &gnt_n);

    // R9
    a_r9_gap_between: assert property (@(posedge clk) disable iff (rst)
        granted |=> (&gnt_n || $stable(gnt_n)));

    // R10
    a_r10_no_request: assert property (@(posedge clk) disable iff (rst)
        (&gnt_n && &req_n) |=> &gnt_n);

endmodule

bind fair_bus_arbiter fair_bus_arbiter_chk #(
    .NUM_AGENTS (NUM_AGENTS),
    .IDLE_LIMIT (IDLE_LIMIT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_n   (req_n),
    .frame_n (frame_n),
    .gnt_n   (gnt_n)
);

// File: tb/fair_bus_arbiter_bench.sv
`timescale 1ns/1ps
module fair_bus_arbiter_bench;

    localparam int NA = 4;
    localparam int IL = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NA-1:0] req_n = '1;
    logic          frame_n = 1'b1;
    logic [NA-1:0] gnt_n;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int m_busy, m_owner, m_last, m_cnt, m_fprev;

    always #2 clk = ~clk;

    fair_bus_arbiter #(.NUM_AGENTS(NA), .IDLE_LIMIT(IL)) u_fair_bus_arbiter (
        .clk     (clk),
        .rst     (rst),
        .req_n   (req_n),
        .frame_n (frame_n),
        .gnt_n   (gnt_n)
    );

    function automatic logic [NA-1:0] model_gnt();
        logic [NA-1:0] v;
        v = '1;
        if (m_busy != 0) v[m_owner] = 1'b0;
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_owner = 0; m_last = NA - 1; m_cnt = 0; m_fprev = 1;
        end else if (m_busy == 0) begin
            for (int k = 1; k <= NA; k++) begin
                int c;
                c = (m_last + k) % NA;
                if (m_busy == 0 && req_n[c] == 1'b0) begin
                    m_busy = 1; m_owner = c; m_last = c; m_cnt = 0;
                end
            end
            m_fprev = int'(frame_n);
        end else begin
            bit rel;
            rel = (m_fprev == 1 && frame_n == 1'b0) || req_n[m_owner] == 1'b1 ||
                  (frame_n == 1'b1 && m_cnt == IL - 1);
            if (frame_n) m_cnt++;
            if (rel) m_busy = 0;
            m_fprev = int'(frame_n);
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [NA-1:0] act, input logic [NA-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s gnt_n actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model (R3, R2)
    always @(negedge clk) begin
        if (!rst) begin
            chk(gnt_n === model_gnt(), "R3 model", gnt_n, model_gnt());
            chk($countones(~gnt_n) <= 1, "R2 one grant", gnt_n, model_gnt());
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        tick(3);
        chk(gnt_n === 4'b1111, "R1 reset", gnt_n, 4'b1111);
        rst = 1'b0;

        tick(4);
        chk(gnt_n === 4'b1111, "R10 no request", gnt_n, 4'b1111);

        req_n = 4'b1011;
        tick(1);
        chk(gnt_n === 4'b1011, "R4 first grant", gnt_n, 4'b1011);

        req_n = 4'b1010;
        tick(5);
        chk(gnt_n === 4'b1011, "R8 hold", gnt_n, 4'b1011);

        frame_n = 1'b0;
        tick(1);
        chk(gnt_n === 4'b1111, "R5 frame start", gnt_n, 4'b1111);
        tick(1);
        chk(gnt_n === 4'b1110, "R9 next after gap", gnt_n, 4'b1110);

        tick(10);
        chk(gnt_n === 4'b1110, "R8 frame held low", gnt_n, 4'b1110);
        frame_n = 1'b1;
        tick(15);
        chk(gnt_n === 4'b1110, "R11 low cycles not counted", gnt_n, 4'b1110);
        tick(1);
        chk(gnt_n === 4'b1111, "R6 timeout", gnt_n, 4'b1111);
        tick(1);
        chk(gnt_n === 4'b1011, "R3 rotate to 2", gnt_n, 4'b1011);

        tick(15);
        chk(gnt_n === 4'b1011, "R11 count restarted", gnt_n, 4'b1011);
        tick(1);
        chk(gnt_n === 4'b1111, "R6 timeout again", gnt_n, 4'b1111);
        tick(1);
        chk(gnt_n === 4'b1110, "R3 wrap to 0", gnt_n, 4'b1110);

        req_n = 4'b1011;
        tick(1);
        chk(gnt_n === 4'b1111, "R7 owner drop", gnt_n, 4'b1111);
        tick(1);
        chk(gnt_n === 4'b1011, "R9 regrant", gnt_n, 4'b1011);
        req_n = 4'b1111;
        tick(1);
        chk(gnt_n === 4'b1111, "R7 last owner drop", gnt_n, 4'b1111);
        tick(3);
        chk(gnt_n === 4'b1111, "R10 idle bus", gnt_n, 4'b1111);

        req_n = 4'b0000;
        tick(1);
        for (int i = 0; i < 8; i++) begin
            int e;
            logic [NA-1:0] ev;
            e  = (3 + i) % NA;
            ev = '1;
            ev[e] = 1'b0;
            chk(gnt_n === ev, "R3 round robin", gnt_n, ev);
            frame_n = 1'b0;
            tick(1);
            chk(gnt_n === 4'b1111, "R5 release in rotation", gnt_n, 4'b1111);
            frame_n = 1'b1;
            tick(1);
        end

        req_n = 4'b1111;
        tick(3);
        finish_run();
    end

endmodule